// File: doc/BRIEF.md
# Round-Robin Output Allocator with Packet Hold

This block shares a set of output resources among many requesters. Each requester is one virtual channel of one input port; there are N ports with M channels each. Every cycle a requester may ask for exactly one of SIZE outputs with a one-hot vector. Each output has its own round-robin arbiter over all N*M requesters. A requester's wins across all outputs are merged into a single grant bit for that requester.

A per-requester blocking flag from downstream stops a requester from being granted in that cycle. An output won by the first flit of a multi-flit packet is then reserved for that requester. The reservation lasts until the requester is granted a flit marked as the packet's last one. Because of this, flits of two packets never mix on one output. A single-flit packet is granted without taking a reservation.

Requesters are numbered r = port*M + channel. That number is the bit order of the merged grant vector and the order in which the round-robin search runs.

Top module: `rrh_alloc`

## Requirements
- R1: In any cycle, each output grants at most one requester, and a requester granted by an output is one whose request vector selects that output.
- R2: A requester whose blocking flag is 1 receives grant 0 in that cycle.
- R3: A requester whose request vector is all zero receives grant 0.
- R4: When an output is not reserved, it grants the first requester in the search order pointer, pointer+1, … , N*M-1, 0, … that requests it and is not blocked. After that grant, its pointer becomes winner+1, wrapping to 0 after N*M-1.
- R5: An output's pointer does not change in a cycle in which it makes no unreserved grant. This includes every cycle in which it is reserved.
- R6: A grant by an unreserved output with tail_done=0 reserves that output for the winner. While it is reserved, no other requester is granted that output.
- R7: A reserved output is released after the cycle in which its owner is granted with tail_done=1. Arbitration resumes from the unchanged pointer in the next cycle.
- R8: A reserved owner that is blocked, or that is not requesting, gets grant 0 while the reservation stays in place.
- R9: A grant with tail_done=1 on an unreserved output takes no reservation.
- R10: Reset is synchronous and active low. It clears all reservations and sets every pointer to 0.
- R11: With every requester asking for the same output with single-flit packets and no blocking, each requester is granted within N*M cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | N*M*SIZE | Per requester, a one-hot output request vector (bit o asks for output o) |
| blocked | input | N*M | Per requester, 1 = downstream is full, do not grant |
| tail_done | input | N*M | Per requester, 1 = the flit now requesting is the last flit of its packet |
| grant | output | N*M | Per requester, 1 = granted its requested output this cycle (bit r = port*M+channel) |

## Verification
The embedded assertions check properties that hold in every cycle:
- no output ever has more than one grantee, and no grant goes to a blocked requester or to an output that was not requested;
- a reserved output keeps its owner until a last-flit grant, and is freed right after that grant;
- a pointer never moves while an output is reserved or idle.

Other behaviour needs chosen input sequences in the bench:
- the exact round-robin order and wrap-around;
- a single-flit grant leaving the output free;
- a blocked owner regaining its output after the block clears;
- the starvation bound under full load.

A cycle-level reference model checks all of these under random packet traffic.

// File: rtl/rrh_pkg.sv
// Shared definitions for the round-robin hold allocator.
// Assumes: requester indices are non-negative and below the limit given.
package rrh_pkg;

    // Reservation state of one output.
    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_mode_e;

    // Next index in a circular order of 'limit' entries.
    function automatic int wrap_next(input int idx, input int limit);
        return (idx >= limit - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rrh_rr_pick.sv
// Combinational round-robin picker.
// Finds the first set bit of 'want' at or after index 'ptr', wrapping around.
// Assumes: ptr < W. Returns the one-hot winner, its index and a found flag.
module rrh_rr_pick #(
    parameter int W  = 20,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  want,
    input  logic [IW-1:0] ptr,
    output logic [W-1:0]  pick_oh,
    output logic [IW-1:0] pick_idx,
    output logic          pick_any
);

    // Circular scan starting from the pointer; the first hit wins.
    always_comb begin
        int c;
        pick_oh  = '0;
        pick_idx = '0;
        pick_any = 1'b0;
        for (int k = 0; k < W; k++) begin
            c = int'(ptr) + k;
            if (c >= W) c = c - W;
            if (!pick_any && want[c]) begin
                pick_any    = 1'b1;
                pick_oh[c]  = 1'b1;
                pick_idx    = IW'(c);
            end
        end
    end

endmodule

// File: rtl/rrh_out_slice.sv
// Arbitration and reservation for one output resource.
// A grant with tail=0 on a free output reserves it for the winner. The
// reservation ends after the owner is granted with tail=1. The pointer moves
// only on an unreserved grant.
// Assumes: 'want' already excludes blocked requesters.
module rrh_out_slice #(
    parameter int W  = 20,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  want,
    input  logic [W-1:0]  tail,
    output logic [W-1:0]  gnt
);
    import rrh_pkg::*;

    slot_mode_e    mode_q;
    logic [IW-1:0] owner_q;
    logic [IW-1:0] ptr_q;
    logic [W-1:0]  pick_oh;
    logic [IW-1:0] pick_idx;
    logic          pick_any;
    logic          owner_go;

    rrh_rr_pick #(.W(W), .IW(IW)) u_pick (
        .want     (want),
        .ptr      (ptr_q),
        .pick_oh  (pick_oh),
        .pick_idx (pick_idx),
        .pick_any (pick_any)
    );

    // The owner may proceed this cycle only if it still requests and is not blocked.
    assign owner_go = want[owner_q];

    // Grant: the owner only while reserved, otherwise the round-robin winner.
    always_comb begin
        gnt = '0;
        if (mode_q == SLOT_HELD) begin
            gnt[owner_q] = owner_go;
        end else begin
            gnt = pick_oh;
        end
    end

    // Reservation and pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= SLOT_FREE;
            owner_q <= '0;
            ptr_q   <= '0;
        end else if (mode_q == SLOT_HELD) begin
            if (owner_go && tail[owner_q]) mode_q <= SLOT_FREE;
        end else if (pick_any) begin
            ptr_q <= IW'(wrap_next(int'(pick_idx), W));
            if (!tail[pick_idx]) begin
                mode_q  <= SLOT_HELD;
                owner_q <= pick_idx;
            end
        end
    end

    // R1: at most one grantee per output per cycle.
    p_one_winner_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R3: a grant always goes to a requester that wants this output.
    p_grant_wanted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~want) == '0);

    // R6: while reserved, nobody but the owner is granted.
    p_only_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SLOT_HELD) |-> ((gnt & ~(W'(1) << owner_q)) == '0));

    // R6 R8: the reservation and its owner persist until a last-flit grant.
    p_hold_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SLOT_HELD && !(want[owner_q] && tail[owner_q]))
        |=> (mode_q == SLOT_HELD && owner_q == $past(owner_q)));

    // R7: a last-flit grant to the owner frees the output.
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SLOT_HELD && want[owner_q] && tail[owner_q])
        |=> (mode_q == SLOT_FREE));

    // R5: the pointer stays put while reserved or idle.
    p_ptr_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SLOT_HELD || want == '0) |=> $stable(ptr_q));

endmodule

// File: rtl/rrh_grant_or.sv
// Merges the per-output grant vectors into one grant bit per requester.
// Assumes: each requester asks for at most one output, so at most one
// output can grant it.
module rrh_grant_or #(
    parameter int W    = 20,
    parameter int SIZE = 5
) (
    input  logic [SIZE-1:0][W-1:0] per_out,
    output logic [W-1:0]           merged
);

    // OR-reduce across outputs.
    always_comb begin
        merged = '0;
        for (int o = 0; o < SIZE; o++) merged = merged | per_out[o];
    end

endmodule

// File: rtl/rrh_alloc.sv
// Top of the round-robin allocator with packet hold.
// N ports with M channels each make N*M requesters, numbered port*M+channel.
// Each of SIZE outputs has its own arbiter slice. Blocked requesters are
// removed before arbitration.
// Assumes: each req[p][c] is one-hot or zero, and a requester keeps one
// target output until its packet's last flit is granted.
module rrh_alloc #(
    parameter int N    = 5,
    parameter int M    = 4,
    parameter int SIZE = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N-1:0][M-1:0][SIZE-1:0]    req,
    input  logic [N-1:0][M-1:0]              blocked,
    input  logic [N-1:0][M-1:0]              tail_done,
    output logic [N-1:0][M-1:0]              grant
);
    localparam int W  = N * M;
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    logic [SIZE-1:0][W-1:0] want_by_out;
    logic [SIZE-1:0][W-1:0] gnt_by_out;
    logic [W-1:0]           tail_flat;
    logic [W-1:0]           blk_flat;
    logic [W-1:0]           merged;

    assign tail_flat = tail_done;
    assign blk_flat  = blocked;
    assign grant     = merged;

    // Reorder requests from per-requester to per-output, masking blocked ones.
    always_comb begin
        for (int o = 0; o < SIZE; o++) begin
            for (int p = 0; p < N; p++) begin
                for (int c = 0; c < M; c++) begin
                    want_by_out[o][p*M + c] = req[p][c][o] & ~blocked[p][c];
                end
            end
        end
    end

    genvar o;
    generate
        for (o = 0; o < SIZE; o++) begin : g_out
            rrh_out_slice #(.W(W), .IW(IW)) u_slice (
                .clk   (clk),
                .rst_n (rst_n),
                .want  (want_by_out[o]),
                .tail  (tail_flat),
                .gnt   (gnt_by_out[o])
            );
        end
    endgenerate

    rrh_grant_or #(.W(W), .SIZE(SIZE)) u_merge (
        .per_out (gnt_by_out),
        .merged  (merged)
    );

    // R2: a blocked requester is never granted.
    p_blocked_no_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (merged & blk_flat) == '0);

endmodule

// File: tb/sim_rrh_alloc.sv
// Bench for rrh_alloc. A behavioural per-output model is advanced on every
// clock and compared with the grant port.
module sim_rrh_alloc;
    localparam int N = 5, M = 4, S = 5, R = N * M;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [N-1:0][M-1:0][S-1:0] req;
    logic [N-1:0][M-1:0]        blocked, tail_done, grant;

    rrh_alloc #(.N(N), .M(M), .SIZE(S)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .blocked(blocked),
        .tail_done(tail_done), .grant(grant)
    );

    int checks = 0;
    int fails  = 0;

    // Stimulus per requester.
    int dst[R];
    bit pres[R], st[R], tl[R];
    int left[R];
    // Reference model per output.
    bit m_held[S];
    int m_own[S];
    int m_ptr[S];
    logic [R-1:0] exp_g;
    int waitc[R];

    task automatic check(input string tag, input logic [R-1:0] act, input logic [R-1:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%05h expected=%05h", tag, act, expv);
        end
    endtask

    function automatic void clear_stim();
        for (int r = 0; r < R; r++) begin
            dst[r] = -1; pres[r] = 1'b1; st[r] = 1'b0; tl[r] = 1'b0; left[r] = 0;
        end
    endfunction

    function automatic void apply();
        req = '0;
        for (int r = 0; r < R; r++) begin
            if (dst[r] >= 0 && pres[r]) req[r/M][r%M][dst[r]] = 1'b1;
            blocked[r/M][r%M]   = st[r];
            tail_done[r/M][r%M] = tl[r];
        end
    endfunction

    function automatic bit wants(input int r, input int o);
        return (dst[r] == o) && pres[r] && !st[r];
    endfunction

    // Expected grants for this cycle; the model state then moves to the next cycle.
    function automatic void model_step();
        exp_g = '0;
        for (int o = 0; o < S; o++) begin
            if (m_held[o]) begin
                if (wants(m_own[o], o)) begin
                    exp_g[m_own[o]] = 1'b1;
                    if (tl[m_own[o]]) m_held[o] = 1'b0;
                end
            end else begin
                for (int k = 0; k < R; k++) begin
                    int r;
                    r = (m_ptr[o] + k) % R;
                    if (wants(r, o)) begin
                        exp_g[r] = 1'b1;
                        m_ptr[o] = (r + 1) % R;
                        if (!tl[r]) begin m_held[o] = 1'b1; m_own[o] = r; end
                        break;
                    end
                end
            end
        end
    endfunction

    // One cycle: drive inputs, compare after settling, advance the model.
    task automatic step();
        logic [R-1:0] act, blk, reqd;
        @(negedge clk);
        apply();
        #2;
        model_step();
        act = grant;
        check("R1 R4 R6 R7 R8 model", act, exp_g);
        blk = '0; reqd = '0;
        for (int r = 0; r < R; r++) begin
            blk[r]  = st[r];
            reqd[r] = (dst[r] >= 0) && pres[r];
        end
        check("R2 blocked grant", act & blk, '0);
        check("R3 idle grant", act & ~reqd, '0);
    endtask

    initial begin
        logic [R-1:0] g;
        clear_stim();
        for (int o = 0; o < S; o++) begin m_held[o] = 0; m_own[o] = 0; m_ptr[o] = 0; end
        apply();
        repeat (3) @(posedge clk);
        #2; g = grant;
        check("R10 grant in reset", g, '0);
        @(negedge clk); rst_n = 1'b1;

        // R10 R4: pointers start at 0, then advance past each winner with wrap.
        dst[0] = 2; dst[19] = 2; tl[0] = 1; tl[19] = 1;
        step(); g = grant; check("R10 first winner is 0", g, R'(1));
        step(); g = grant; check("R4 next winner is 19", g, R'(1) << 19);
        step(); g = grant; check("R4 wrap to 0", g, R'(1));
        // R9: a single-flit grant takes no reservation.
        clear_stim(); dst[4] = 3; tl[4] = 1;
        step(); g = grant; check("R9 single flit granted", g, R'(1) << 4);
        dst[4] = -1; dst[8] = 3; tl[8] = 1;
        step(); g = grant; check("R9 output stays free", g, R'(1) << 8);

        // R6 R8 R7 R5: reservation on output 1.
        clear_stim(); dst[5] = 1;
        step(); g = grant; check("R6 head flit wins", g, R'(1) << 5);
        dst[2] = 1; dst[6] = 1; tl[2] = 1; tl[6] = 1;
        step(); g = grant; check("R6 only owner granted", g, R'(1) << 5);
        st[5] = 1;
        step(); g = grant; check("R8 blocked owner, nobody granted", g, '0);
        st[5] = 0; pres[5] = 0;
        step(); g = grant; check("R8 idle owner, nobody granted", g, '0);
        pres[5] = 1; tl[5] = 1;
        step(); g = grant; check("R7 owner tail granted", g, R'(1) << 5);
        dst[5] = -1;
        step(); g = grant; check("R5 R7 pointer kept at 6", g, R'(1) << 6);
        dst[6] = -1;
        step(); g = grant; check("R4 wrap to 2", g, R'(1) << 2);

        // R11: full load on output 0.
        clear_stim();
        for (int r = 0; r < R; r++) begin dst[r] = 0; tl[r] = 1; waitc[r] = 0; end
        for (int c = 0; c < 3 * R; c++) begin
            int worst;
            step();
            g = grant; worst = 0;
            for (int r = 0; r < R; r++) begin
                if (g[r]) waitc[r] = 0; else waitc[r]++;
                if (waitc[r] > worst) worst = waitc[r];
            end
            checks++;
            if (worst >= R) begin
                fails++;
                $display("FAIL R11 wait actual=%0d expected<%0d", worst, R);
            end
        end

        // Random multi-flit traffic with bubbles and blocking.
        clear_stim();
        for (int c = 0; c < 3000; c++) begin
            for (int r = 0; r < R; r++) begin
                if (left[r] == 0) begin
                    if ($urandom % 4 == 0) begin
                        dst[r] = int'($urandom % S); left[r] = 1 + int'($urandom % 3);
                    end else dst[r] = -1;
                end
                pres[r] = ($urandom % 5) != 0;
                st[r]   = ($urandom % 5) == 0;
                tl[r]   = (left[r] == 1);
            end
            step();
            for (int r = 0; r < R; r++) if (exp_g[r] && left[r] > 0) left[r]--;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule